// File: doc/BRIEF.md
# Palette Processor Register Port

This block is the byte-wide processor-side port of a colour palette. A host reaches four registers through two active-low strobes (read and write) and a 2-bit select. The registers are a table address, a staging buffer for one 18-bit colour entry, and the pixel mask. The address has one write-mode view and one read-mode view of the same physical register. Colour entries cross the port as three 6-bit bytes in the order red, green, blue. The block counts those bytes. It raises one-cycle table write or table read requests toward the table-transfer logic and advances the address by itself, so consecutive entries can be streamed without rewriting the address.

The strobes arrive asynchronously and are brought into the block's system clock through a short synchroniser chain. The select is captured when the active strobe is seen to fall. Write data is taken when the write strobe is seen to rise. Read data is presented with a separate output-enable that an outer pad ring turns into a tri-state driver. Table contents come back through a read-valid handshake from the table side. The pixel mask is exported as a plain register output for the pixel path.

Top module: `palette_cpu_port`

## Requirements
- R1: Select 00 writes the address in write mode. A read at select 00 and a read at select 11 both return the current address.
- R2: Select 10 writes the pixel mask. A read at select 10 returns it, and the `pix_mask` output follows it.
- R3: Writes at select 01 fill red, green and blue in turn, keeping data bits 5:0. After the blue write the block issues one table write request at the current address with red in bits 17:12, green in 11:6 and blue in 5:0. The address then becomes that address plus one.
- R4: The address is 8 bits wide and wraps from 255 to 0 on every increment.
- R5: Writing the address at select 11 issues one table read request at the written value. The buffer is loaded with the returned entry, and the address becomes the written value plus one.
- R6: Reads at select 01 return red, green, then blue from the buffer in data bits 5:0 with bits 7:6 zero. After the blue read the block issues a table read request at the current address and increments the address.
- R7: Any address write (select 00 or 11) abandons a partly transferred triplet, so the next colour access is red.
- R8: `cpu_dout_oe` is high while a read is in progress and falls within a few clock cycles after the read strobe rises.
- R9: After reset the address is 0, the next colour byte is red, the mask is all ones, no request is active and the output enable is low.
- R10: Table write and read requests are single-cycle pulses and are never active in the same cycle.
- R11: The select is captured when the strobe falls. A change of select while the strobe is low has no effect on which register is written.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst | input | 1 | Synchronous active-high reset |
| cpu_rd_n | input | 1 | Read strobe, active low, asynchronous |
| cpu_wr_n | input | 1 | Write strobe, active low, asynchronous |
| cpu_sel | input | 2 | Register select |
| cpu_din | input | DATA_W | Write data from the host |
| cpu_dout | output | DATA_W | Read data toward the host |
| cpu_dout_oe | output | 1 | Drive enable for read data |
| pix_mask | output | ADDR_W | Pixel mask register |
| tbl_wr_req | output | 1 | One-cycle table write request |
| tbl_rd_req | output | 1 | One-cycle table read request |
| tbl_addr | output | ADDR_W | Table location of the current request |
| tbl_wdata | output | 3*CH_W | Entry to write, red in the top field |
| tbl_rd_vld | input | 1 | Returned table entry is valid |
| tbl_rd_data | input | 3*CH_W | Returned table entry |

## Verification
A wrong byte counter shows at once as a colour byte returned or stored in the wrong field. It also shows as a table write landing one or two bytes early. A full sweep of all 256 entries written and read back exposes this within one triplet. A wrong address or a missing increment shows as a mismatch at the next table location touched, or when the address is read back directly after a wrap. A bad abort shows as the first byte after an address write landing in green or blue rather than red. A stuck output enable is caught on the first read that follows.

// File: rtl/pal_pkg.sv
package pal_pkg;
  typedef enum logic [1:0] {
    SEL_ADDR_WR = 2'b00,
    SEL_COLOUR  = 2'b01,
    SEL_MASK    = 2'b10,
    SEL_ADDR_RD = 2'b11
  } pal_sel_e;
endpackage

// File: rtl/pal_strobe_sync.sv
module pal_strobe_sync #(
  parameter int STAGES = 2
) (
  input  logic clk,
  input  logic rst,
  input  logic strobe_n,
  output logic active,
  output logic start,
  output logic finish
);
  logic [STAGES-1:0] chain;
  logic              prev;

  generate
    if (STAGES == 1) begin : g_one
      always_ff @(posedge clk) begin
        if (rst) chain <= '0;
        else     chain <= ~strobe_n;
      end
    end else begin : g_many
      always_ff @(posedge clk) begin
        if (rst) chain <= '0;
        else     chain <= {chain[STAGES-2:0], ~strobe_n};
      end
    end
  endgenerate

  always_ff @(posedge clk) begin
    if (rst) prev <= 1'b0;
    else     prev <= chain[STAGES-1];
  end

  assign active = chain[STAGES-1];
  assign start  = active & ~prev;
  assign finish = ~active & prev;
endmodule

// File: rtl/pal_addr_seq.sv
module pal_addr_seq
  import pal_pkg::*;
#(
  parameter int ADDR_W = 8,
  parameter int DATA_W = 8
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              wr_end,
  input  logic              rd_end,
  input  pal_sel_e          sel,
  input  logic [DATA_W-1:0] wdata,
  output logic [ADDR_W-1:0] addr,
  output logic [1:0]        idx,
  output logic [ADDR_W-1:0] mask,
  output logic              tbl_wr_req,
  output logic              tbl_rd_req,
  output logic [ADDR_W-1:0] tbl_addr
);
  localparam logic [1:0] LAST = 2'd2;

  logic [ADDR_W-1:0] din_addr;
  assign din_addr = wdata[ADDR_W-1:0];

  always_ff @(posedge clk) begin
    if (rst) begin
      addr       <= '0;
      idx        <= '0;
      mask       <= '1;
      tbl_wr_req <= 1'b0;
      tbl_rd_req <= 1'b0;
      tbl_addr   <= '0;
    end else begin
      tbl_wr_req <= 1'b0;
      tbl_rd_req <= 1'b0;
      if (wr_end) begin
        case (sel)
          SEL_ADDR_WR: begin
            addr <= din_addr;
            idx  <= '0;
          end
          SEL_ADDR_RD: begin
            addr       <= din_addr + 1'b1;
            idx        <= '0;
            tbl_rd_req <= 1'b1;
            tbl_addr   <= din_addr;
          end
          SEL_COLOUR: begin
            if (idx == LAST) begin
              idx        <= '0;
              tbl_wr_req <= 1'b1;
              tbl_addr   <= addr;
              addr       <= addr + 1'b1;
            end else begin
              idx <= idx + 1'b1;
            end
          end
          default: mask <= din_addr;
        endcase
      end else if (rd_end && sel == SEL_COLOUR) begin
        if (idx == LAST) begin
          idx        <= '0;
          tbl_rd_req <= 1'b1;
          tbl_addr   <= addr;
          addr       <= addr + 1'b1;
        end else begin
          idx <= idx + 1'b1;
        end
      end
    end
  end

  AST_ONE_REQ: assert property (@(posedge clk) disable iff (rst)
    !(tbl_wr_req && tbl_rd_req)); // R10
  AST_WR_PULSE: assert property (@(posedge clk) disable iff (rst)
    tbl_wr_req |=> !tbl_wr_req); // R10
  AST_WR_INC: assert property (@(posedge clk) disable iff (rst)
    tbl_wr_req |-> addr == ADDR_W'(tbl_addr + 1'b1)); // R3
  AST_RD_INC: assert property (@(posedge clk) disable iff (rst)
    tbl_rd_req |-> addr == ADDR_W'(tbl_addr + 1'b1)); // R5
  AST_IDX_RANGE: assert property (@(posedge clk) disable iff (rst)
    idx != 2'd3); // R6
  AST_ABORT: assert property (@(posedge clk) disable iff (rst)
    (wr_end && (sel == SEL_ADDR_WR || sel == SEL_ADDR_RD)) |=> idx == 2'd0); // R7
endmodule

// File: rtl/pal_colour_buf.sv
module pal_colour_buf #(
  parameter int CH_W = 6
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              byte_we,
  input  logic [1:0]        idx,
  input  logic [CH_W-1:0]   byte_in,
  input  logic              load,
  input  logic [3*CH_W-1:0] load_data,
  output logic [3*CH_W-1:0] entry,
  output logic [CH_W-1:0]   byte_out
);
  logic [CH_W-1:0] ch [3];

  always_ff @(posedge clk) begin
    if (rst) begin
      for (int k = 0; k < 3; k++) ch[k] <= '0;
    end else if (load) begin
      for (int k = 0; k < 3; k++) ch[k] <= load_data[(2-k)*CH_W +: CH_W];
    end else if (byte_we) begin
      for (int k = 0; k < 3; k++)
        if (idx == 2'(k)) ch[k] <= byte_in;
    end
  end

  assign entry = {ch[0], ch[1], ch[2]};

  always_comb begin
    case (idx)
      2'd0:    byte_out = ch[0];
      2'd1:    byte_out = ch[1];
      default: byte_out = ch[2];
    endcase
  end

  AST_LOAD_TAKES: assert property (@(posedge clk) disable iff (rst)
    load |=> entry == $past(load_data)); // R5
endmodule

// File: rtl/palette_cpu_port.sv
module palette_cpu_port
  import pal_pkg::*;
#(
  parameter int ADDR_W      = 8,
  parameter int CH_W        = 6,
  parameter int DATA_W      = 8,
  parameter int SYNC_STAGES = 2
) (
  input  logic                clk,
  input  logic                rst,
  input  logic                cpu_rd_n,
  input  logic                cpu_wr_n,
  input  logic [1:0]          cpu_sel,
  input  logic [DATA_W-1:0]   cpu_din,
  output logic [DATA_W-1:0]   cpu_dout,
  output logic                cpu_dout_oe,
  output logic [ADDR_W-1:0]   pix_mask,
  output logic                tbl_wr_req,
  output logic                tbl_rd_req,
  output logic [ADDR_W-1:0]   tbl_addr,
  output logic [3*CH_W-1:0]   tbl_wdata,
  input  logic                tbl_rd_vld,
  input  logic [3*CH_W-1:0]   tbl_rd_data
);
  localparam int ENTRY_W = 3 * CH_W;

  logic w_act, w_start, w_finish;
  logic r_act, r_start, r_finish;
  pal_sel_e sel_q;
  logic [ADDR_W-1:0]  addr;
  logic [1:0]         idx;
  logic [CH_W-1:0]    byte_out;
  logic [ENTRY_W-1:0] entry;

  pal_strobe_sync #(.STAGES(SYNC_STAGES)) u_wsync (
    .clk(clk), .rst(rst), .strobe_n(cpu_wr_n),
    .active(w_act), .start(w_start), .finish(w_finish));

  pal_strobe_sync #(.STAGES(SYNC_STAGES)) u_rsync (
    .clk(clk), .rst(rst), .strobe_n(cpu_rd_n),
    .active(r_act), .start(r_start), .finish(r_finish));

  always_ff @(posedge clk) begin
    if (rst)                     sel_q <= SEL_ADDR_WR;
    else if (w_start || r_start) sel_q <= pal_sel_e'(cpu_sel);
  end

  pal_addr_seq #(.ADDR_W(ADDR_W), .DATA_W(DATA_W)) u_seq (
    .clk(clk), .rst(rst),
    .wr_end(w_finish), .rd_end(r_finish),
    .sel(sel_q), .wdata(cpu_din),
    .addr(addr), .idx(idx), .mask(pix_mask),
    .tbl_wr_req(tbl_wr_req), .tbl_rd_req(tbl_rd_req), .tbl_addr(tbl_addr));

  pal_colour_buf #(.CH_W(CH_W)) u_buf (
    .clk(clk), .rst(rst),
    .byte_we(w_finish && sel_q == SEL_COLOUR),
    .idx(idx), .byte_in(cpu_din[CH_W-1:0]),
    .load(tbl_rd_vld), .load_data(tbl_rd_data),
    .entry(entry), .byte_out(byte_out));

  assign tbl_wdata = entry;

  always_ff @(posedge clk) begin
    if (rst) begin
      cpu_dout    <= '0;
      cpu_dout_oe <= 1'b0;
    end else if (r_start) begin
      cpu_dout_oe <= 1'b1;
      case (pal_sel_e'(cpu_sel))
        SEL_COLOUR: cpu_dout <= DATA_W'(byte_out);
        SEL_MASK:   cpu_dout <= DATA_W'(pix_mask);
        default:    cpu_dout <= DATA_W'(addr);
      endcase
    end else if (r_finish) begin
      cpu_dout_oe <= 1'b0;
    end
  end

  AST_OE_RISE: assert property (@(posedge clk) disable iff (rst)
    r_start |=> cpu_dout_oe); // R8
  AST_OE_DROP: assert property (@(posedge clk) disable iff (rst)
    r_finish |=> !cpu_dout_oe); // R8
  AST_OE_IDLE: assert property (@(posedge clk) disable iff (rst)
    (!r_act && !r_finish) |=> !cpu_dout_oe); // R8
  AST_TOP_ZERO: assert property (@(posedge clk) disable iff (rst)
    (cpu_dout_oe && sel_q == SEL_COLOUR) |-> cpu_dout[DATA_W-1:CH_W] == '0); // R6
endmodule

// File: tb/sim_palette_cpu_port.sv
module sim_palette_cpu_port;
  logic        clk = 1'b0;
  logic        rst = 1'b1;
  logic        cpu_rd_n = 1'b1;
  logic        cpu_wr_n = 1'b1;
  logic [1:0]  cpu_sel = 2'b00;
  logic [7:0]  cpu_din = 8'h00;
  logic [7:0]  cpu_dout;
  logic        cpu_dout_oe;
  logic [7:0]  pix_mask;
  logic        tbl_wr_req, tbl_rd_req;
  logic [7:0]  tbl_addr;
  logic [17:0] tbl_wdata;
  logic        tbl_rd_vld;
  logic [17:0] tbl_rd_data;

  int total = 0;
  int bad = 0;
  bit done = 1'b0;

  always #2 clk = ~clk;

  palette_cpu_port u0 (
    .clk(clk), .rst(rst), .cpu_rd_n(cpu_rd_n), .cpu_wr_n(cpu_wr_n),
    .cpu_sel(cpu_sel), .cpu_din(cpu_din), .cpu_dout(cpu_dout),
    .cpu_dout_oe(cpu_dout_oe), .pix_mask(pix_mask),
    .tbl_wr_req(tbl_wr_req), .tbl_rd_req(tbl_rd_req), .tbl_addr(tbl_addr),
    .tbl_wdata(tbl_wdata), .tbl_rd_vld(tbl_rd_vld), .tbl_rd_data(tbl_rd_data));

  // table model with two-cycle read latency, plus request monitor
  logic [17:0] mem [256];
  logic        pend;
  logic [7:0]  pend_addr;
  int          wr_cnt, rd_cnt, req_viol;
  logic        prev_wr, prev_rd;

  always @(posedge clk) begin
    if (rst) begin
      for (int i = 0; i < 256; i++) mem[i] <= '0;
      pend <= 1'b0; pend_addr <= '0;
      tbl_rd_vld <= 1'b0; tbl_rd_data <= '0;
      wr_cnt <= 0; rd_cnt <= 0; req_viol <= 0;
      prev_wr <= 1'b0; prev_rd <= 1'b0;
    end else begin
      if (tbl_wr_req) begin
        mem[tbl_addr] <= tbl_wdata;
        wr_cnt <= wr_cnt + 1;
      end
      pend      <= tbl_rd_req;
      pend_addr <= tbl_addr;
      if (tbl_rd_req) rd_cnt <= rd_cnt + 1;
      tbl_rd_vld  <= pend;
      tbl_rd_data <= mem[pend_addr];
      prev_wr <= tbl_wr_req;
      prev_rd <= tbl_rd_req;
      if ((tbl_wr_req && tbl_rd_req) || (tbl_wr_req && prev_wr) || (tbl_rd_req && prev_rd))
        req_viol <= req_viol + 1;
    end
  end

  task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
    total++;
    if (act !== exp) begin
      bad++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  task automatic cpu_write(input logic [1:0] s, input logic [7:0] d);
    @(negedge clk);
    cpu_sel = s; cpu_din = d; cpu_wr_n = 1'b0;
    repeat (8) @(negedge clk);
    cpu_wr_n = 1'b1;
    repeat (8) @(negedge clk);
  endtask

  task automatic cpu_read(input logic [1:0] s, output logic [7:0] d);
    @(negedge clk);
    cpu_sel = s; cpu_rd_n = 1'b0;
    repeat (8) @(negedge clk);
    d = cpu_dout;
    chk("R8 oe during read", 32'(cpu_dout_oe), 32'd1);
    cpu_rd_n = 1'b1;
    repeat (8) @(negedge clk);
    chk("R8 oe after read", 32'(cpu_dout_oe), 32'd0);
  endtask

  function automatic logic [17:0] col(input int i);
    col = {6'(i), 6'(i * 5 + 1), 6'(i ^ 42)};
  endfunction

  initial begin
    repeat (200000) @(posedge clk);
    if (!done) begin
      bad++; total++;
      $display("FAIL watchdog actual=expired expected=finished");
      $display("test done: total=%0d bad=%0d", total, bad);
      $finish;
    end
  end

  initial begin
    logic [7:0] v, v2;
    logic [17:0] e;
    repeat (4) @(negedge clk);
    rst = 1'b0;
    @(negedge clk);
    // R9 reset state
    chk("R9 mask reset", 32'(pix_mask), 32'hFF);
    chk("R9 oe reset", 32'(cpu_dout_oe), 32'd0);
    chk("R9 no requests", 32'({tbl_wr_req, tbl_rd_req}), 32'd0);
    cpu_read(2'b00, v);
    chk("R9 address reset", 32'(v), 32'd0);
    cpu_read(2'b10, v);
    chk("R2 mask read reset", 32'(v), 32'hFF);

    // R2 mask write/read
    cpu_write(2'b10, 8'hA5);
    chk("R2 mask port", 32'(pix_mask), 32'hA5);
    cpu_read(2'b10, v);
    chk("R2 mask readback", 32'(v), 32'hA5);

    // R3 full sweep, top data bits set to junk that must be dropped
    cpu_write(2'b00, 8'h00);
    for (int i = 0; i < 256; i++) begin
      e = col(i);
      cpu_write(2'b01, {2'(i), e[17:12]});
      cpu_write(2'b01, {2'(i + 1), e[11:6]});
      cpu_write(2'b01, {2'(i + 2), e[5:0]});
      chk("R3 table entry", 32'(mem[i]), 32'(e));
    end
    chk("R3 write count", 32'(wr_cnt), 32'd256);
    cpu_read(2'b00, v);
    chk("R4 address wrapped", 32'(v), 32'd0);

    // R5/R6 sweep read back
    cpu_write(2'b11, 8'h00);
    chk("R5 read request count", 32'(rd_cnt), 32'd1);
    for (int i = 0; i < 256; i++) begin
      e = col(i);
      cpu_read(2'b01, v);
      chk("R6 red", 32'(v), 32'(e[17:12]));
      cpu_read(2'b01, v);
      chk("R6 green", 32'(v), 32'(e[11:6]));
      cpu_read(2'b01, v);
      chk("R6 blue", 32'(v), 32'(e[5:0]));
    end
    cpu_read(2'b11, v);
    cpu_read(2'b00, v2);
    chk("R6 address after reads", 32'(v), 32'd1);
    chk("R1 both address views", 32'(v2), 32'(v));

    // R7 abort of a partial write triplet
    cpu_write(2'b00, 8'h10);
    cpu_write(2'b01, 8'd1);
    cpu_write(2'b01, 8'd2);
    cpu_write(2'b00, 8'h20);
    cpu_write(2'b01, 8'd3);
    cpu_write(2'b01, 8'd4);
    cpu_write(2'b01, 8'd5);
    chk("R7 new entry", 32'(mem[8'h20]), 32'({6'd3, 6'd4, 6'd5}));
    chk("R7 old entry kept", 32'(mem[8'h10]), 32'(col(16)));
    cpu_read(2'b00, v);
    chk("R3 address after write", 32'(v), 32'h21);

    // R4 wrap on colour write
    cpu_write(2'b00, 8'hFF);
    cpu_write(2'b01, 8'd7);
    cpu_write(2'b01, 8'd8);
    cpu_write(2'b01, 8'd9);
    chk("R4 entry 255", 32'(mem[255]), 32'({6'd7, 6'd8, 6'd9}));
    cpu_read(2'b00, v);
    chk("R4 wrap after write", 32'(v), 32'd0);

    // R7 abort of a partial read triplet
    cpu_write(2'b11, 8'd5);
    cpu_read(2'b01, v);
    e = col(5);
    chk("R5 red of entry 5", 32'(v), 32'(e[17:12]));
    cpu_write(2'b11, 8'd7);
    e = col(7);
    cpu_read(2'b01, v);
    chk("R7 read restarts red", 32'(v), 32'(e[17:12]));
    cpu_read(2'b01, v);
    chk("R7 green", 32'(v), 32'(e[11:6]));
    cpu_read(2'b01, v);
    chk("R7 blue", 32'(v), 32'(e[5:0]));
    cpu_read(2'b11, v);
    chk("R6 prefetch increment", 32'(v), 32'd9);

    // R5 read-mode address at 255 wraps
    cpu_write(2'b11, 8'hFF);
    cpu_read(2'b00, v);
    chk("R5 address plus one", 32'(v), 32'd0);
    cpu_read(2'b01, v);
    chk("R5 buffer loaded", 32'(v), 32'd7);

    // R11 select changes while strobe is low
    cpu_write(2'b00, 8'h33);
    @(negedge clk);
    cpu_sel = 2'b10; cpu_din = 8'h5A; cpu_wr_n = 1'b0;
    repeat (8) @(negedge clk);
    cpu_sel = 2'b00;
    repeat (2) @(negedge clk);
    cpu_wr_n = 1'b1;
    repeat (8) @(negedge clk);
    chk("R11 mask written", 32'(pix_mask), 32'h5A);
    cpu_read(2'b00, v);
    chk("R11 address untouched", 32'(v), 32'h33);

    chk("R10 request pulses", 32'(req_viol), 32'd0);

    done = 1'b1;
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end
endmodule